// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This unit turns the operand reference of one decoded instruction into an operand value. A request carries a 3-bit mode code, an address field, a register selector and the current stack pointer. The unit samples all of them on the cycle its start input is accepted. From then on a small sequencer performs whatever the mode needs. It may read the register file through a combinational read port. It may make zero, one or two reads through a synchronous memory port whose data returns one cycle after the request. It ends by presenting the effective address and the operand together with a one-cycle done strobe.

Mode codes are: 0 immediate, 1 direct, 2 indirect, 3 register, 4 register indirect, 5 displacement, 6 stack, and 7 illegal. The results stay on the outputs until the next done. A new request may be raised in the same cycle in which done is high, so a decoder can stream requests with no idle cycle between them.

Top module: `opnd_resolver`

## Requirements
- R1: Mode 0 gives the address field, sign-extended from its top bit to the data width, as the operand. The effective address is 0, no memory read is made, and done rises on the second clock edge after start is sampled.
- R2: Mode 1 makes exactly one memory read at the address field. The operand is the word returned and the effective address is the address field. Done rises on the third edge after start is sampled.
- R3: Mode 2 makes exactly two memory reads. The first is at the address field. The second is at the low address-width bits of the word the first read returned. The effective address is that second address, the operand is the second word, and done rises on the fourth edge.
- R4: Mode 3 gives the content of the selected register as the operand. The effective address is 0, no memory read is made, and done rises on the second edge.
- R5: Mode 4 makes one memory read at the low address-width bits of the selected register. That address is the effective address, and done rises on the third edge.
- R6: Mode 5 uses the address field, sign-extended, plus the low bits of the selected register as the effective address, modulo 2^address-width, so any carry out is dropped. One memory read is made there, and done rises on the third edge.
- R7: Mode 6 makes one memory read at the stack pointer value sampled with start. That value is the effective address, and done rises on the third edge.
- R8: Mode 7 raises the error flag in the done cycle only. The operand and effective address are 0, no memory read is made, and done rises on the second edge.
- R9: Done is high for exactly one cycle per accepted request and is low out of reset. The effective address, the operand, the error flag and busy are also low out of reset.
- R10: Busy is high from the edge that accepts start until the edge that raises done. Start and all request inputs are ignored while busy, and memory reads are only made while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| mode | input | 3 | Addressing mode code |
| addrField | input | AW | Address field / immediate / displacement |
| regSel | input | log2(NREG) | Register selector |
| stackPtr | input | AW | Current stack pointer |
| memRdEn | output | 1 | Memory read request |
| memRdAddr | output | AW | Memory read address |
| memRdData | input | DW | Memory read data, one cycle after request |
| regRdSel | output | log2(NREG) | Register file read select |
| regRdData | input | DW | Register file read data, same cycle |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| effAddr | output | AW | Resolved effective address |
| operand | output | DW | Resolved operand |
| modeErr | output | 1 | Illegal mode, valid with done |

## Verification
The result strobe of one request and the acceptance of the next can share a cycle. The bench's driver raises start again on the very cycle it observes done. This is done across every mode, including after the one-cycle modes where the gap would be tightest. The following request is then judged by its own latency, its read count, its first read address and its values, and done must never stay high on two consecutive cycles. A second overlap is provoked by raising start with different inputs while a memory mode is still busy. The result must match the original request, and no extra done may appear.

// File: rtl/opres_pkg.sv
package opres_pkg;

  typedef enum logic [2:0] {
    AM_IMM  = 3'd0,
    AM_DIR  = 3'd1,
    AM_IND  = 3'd2,
    AM_REG  = 3'd3,
    AM_RIND = 3'd4,
    AM_DISP = 3'd5,
    AM_STK  = 3'd6,
    AM_BAD  = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_DECODE,
    SQ_PTR,
    SQ_WAIT
  } seq_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic capIn;    // sample request inputs
    logic issue;    // drive a memory read this cycle
    logic ptrStep;  // read address comes from returned pointer word
    logic finImm;   // finish with immediate operand
    logic finReg;   // finish with register operand
    logic finErr;   // finish with illegal-mode error
    logic finMem;   // finish with memory data
  } ctl_t;

endpackage

// File: rtl/opres_ctrl.sv
module opres_ctrl
  import opres_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  amode_e curMode,
  output ctl_t   ctl,
  output logic   busy
);

  seq_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= SQ_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      SQ_IDLE: begin
        if (start) begin
          ctl.capIn = 1'b1;
          nextState = SQ_DECODE;
        end
      end
      SQ_DECODE: begin
        unique case (curMode)
          AM_IMM: begin ctl.finImm = 1'b1; nextState = SQ_IDLE; end
          AM_REG: begin ctl.finReg = 1'b1; nextState = SQ_IDLE; end
          AM_BAD: begin ctl.finErr = 1'b1; nextState = SQ_IDLE; end
          AM_IND: begin ctl.issue  = 1'b1; nextState = SQ_PTR;  end
          default: begin ctl.issue = 1'b1; nextState = SQ_WAIT; end
        endcase
      end
      SQ_PTR: begin
        ctl.issue   = 1'b1;
        ctl.ptrStep = 1'b1;
        nextState   = SQ_WAIT;
      end
      SQ_WAIT: begin
        ctl.finMem = 1'b1;
        nextState  = SQ_IDLE;
      end
      default: nextState = SQ_IDLE;
    endcase
  end

  assign busy = (state != SQ_IDLE);

endmodule

// File: rtl/opres_dp.sv
module opres_dp
  import opres_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 8,
  parameter int RSW = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctl_t           ctl,
  input  logic [2:0]     mode,
  input  logic [AW-1:0]  addrField,
  input  logic [RSW-1:0] regSel,
  input  logic [AW-1:0]  stackPtr,
  output amode_e         curMode,
  output logic           memRdEn,
  output logic [AW-1:0]  memRdAddr,
  input  logic [DW-1:0]  memRdData,
  output logic [RSW-1:0] regRdSel,
  input  logic [DW-1:0]  regRdData,
  output logic [AW-1:0]  effAddr,
  output logic [DW-1:0]  operand,
  output logic           done,
  output logic           modeErr
);

  amode_e         modeQ;
  logic [AW-1:0]  fieldQ;
  logic [RSW-1:0] selQ;
  logic [AW-1:0]  spQ;
  logic [AW-1:0]  eaHold;
  logic [AW-1:0]  eaCalc;
  logic [DW-1:0]  immExt;
  logic [AW-1:0]  regLow;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= AM_IMM;
      fieldQ <= '0;
      selQ   <= '0;
      spQ    <= '0;
    end else if (ctl.capIn) begin
      modeQ  <= amode_e'(mode);
      fieldQ <= addrField;
      selQ   <= regSel;
      spQ    <= stackPtr;
    end
  end

  assign curMode  = modeQ;
  assign regRdSel = selQ;
  assign regLow   = regRdData[AW-1:0];

  // immediate widening
  generate
    if (DW > AW) begin : g_ext
      assign immExt = {{(DW-AW){fieldQ[AW-1]}}, fieldQ};
    end else begin : g_same
      assign immExt = fieldQ[DW-1:0];
    end
  endgenerate

  // effective address of the first read
  always_comb begin
    unique case (modeQ)
      AM_DIR,
      AM_IND:  eaCalc = fieldQ;
      AM_RIND: eaCalc = regLow;
      AM_DISP: eaCalc = regLow + fieldQ;  // sign extension to AW is identity; carry dropped
      AM_STK:  eaCalc = spQ;
      default: eaCalc = '0;
    endcase
  end

  assign memRdEn   = ctl.issue;
  assign memRdAddr = ctl.ptrStep ? memRdData[AW-1:0] : eaCalc;

  always_ff @(posedge clk) begin
    if (!rstN)          eaHold <= '0;
    else if (ctl.issue) eaHold <= memRdAddr;
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      modeErr <= 1'b0;
      effAddr <= '0;
      operand <= '0;
    end else begin
      done    <= ctl.finImm | ctl.finReg | ctl.finErr | ctl.finMem;
      modeErr <= ctl.finErr;
      if (ctl.finImm) begin
        operand <= immExt;
        effAddr <= '0;
      end else if (ctl.finReg) begin
        operand <= regRdData;
        effAddr <= '0;
      end else if (ctl.finErr) begin
        operand <= '0;
        effAddr <= '0;
      end else if (ctl.finMem) begin
        operand <= memRdData;
        effAddr <= eaHold;
      end
    end
  end

endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opres_pkg::*;
#(
  parameter  int DW   = 16,
  parameter  int AW   = 8,
  parameter  int NREG = 8,
  localparam int RSW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [2:0]     mode,
  input  logic [AW-1:0]  addrField,
  input  logic [RSW-1:0] regSel,
  input  logic [AW-1:0]  stackPtr,
  output logic           memRdEn,
  output logic [AW-1:0]  memRdAddr,
  input  logic [DW-1:0]  memRdData,
  output logic [RSW-1:0] regRdSel,
  input  logic [DW-1:0]  regRdData,
  output logic           busy,
  output logic           done,
  output logic [AW-1:0]  effAddr,
  output logic [DW-1:0]  operand,
  output logic           modeErr
);

  ctl_t   ctl;
  amode_e curMode;

  opres_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .curMode (curMode),
    .ctl     (ctl),
    .busy    (busy)
  );

  opres_dp #(.DW(DW), .AW(AW), .RSW(RSW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .mode      (mode),
    .addrField (addrField),
    .regSel    (regSel),
    .stackPtr  (stackPtr),
    .curMode   (curMode),
    .memRdEn   (memRdEn),
    .memRdAddr (memRdAddr),
    .memRdData (memRdData),
    .regRdSel  (regRdSel),
    .regRdData (regRdData),
    .effAddr   (effAddr),
    .operand   (operand),
    .done      (done),
    .modeErr   (modeErr)
  );

endmodule

// File: rtl/opres_chk.sv
module opres_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          modeErr,
  input logic          memRdEn,
  input logic [AW-1:0] memRdAddr,
  input logic [AW-1:0] effAddr
);

  // R9: done never lasts two cycles
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: error flag only together with done
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> done);

  // R10: reads only while busy
  a_r10_read_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

  // R10: accepted start makes the unit busy
  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R2: for memory modes the effective address is the last read address
  a_r2_ea_last_read: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(memRdEn, 2)) |-> (effAddr == $past(memRdAddr, 2)));

  // R4: without a read the effective address is zero
  a_r4_no_addr_without_read: assert property (@(posedge clk) disable iff (!rstN)
    (done && !$past(memRdEn, 2)) |-> (effAddr == '0));

endmodule

bind opnd_resolver opres_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .modeErr   (modeErr),
  .memRdEn   (memRdEn),
  .memRdAddr (memRdAddr),
  .effAddr   (effAddr)
);

// File: tb/sim_opnd_resolver.sv
`timescale 1ns/100ps
module sim_opnd_resolver;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [2:0]  mode;
  logic [7:0]  addrField;
  logic [2:0]  regSel;
  logic [7:0]  stackPtr;
  logic        memRdEn;
  logic [7:0]  memRdAddr;
  logic [15:0] memRdData = '0;
  logic [2:0]  regRdSel;
  logic [15:0] regRdData;
  logic        busy, done, modeErr;
  logic [7:0]  effAddr;
  logic [15:0] operand;

  int errCnt = 0;
  int chkCnt = 0;
  int doneSeen = 0;
  int issued = 0;

  always #2.5 clk = ~clk;

  opnd_resolver u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .addrField(addrField),
    .regSel(regSel), .stackPtr(stackPtr), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .regRdSel(regRdSel), .regRdData(regRdData),
    .busy(busy), .done(done), .effAddr(effAddr), .operand(operand), .modeErr(modeErr)
  );

  function automatic logic [15:0] memWord(input logic [7:0] a);
    return {a ^ 8'hA5, a + 8'h11};
  endfunction

  function automatic logic [15:0] rfWord(input logic [2:0] i);
    logic [7:0] hi, lo;
    hi = 8'(int'(i) * 16 + 3);
    lo = 8'(int'(i) * 29 + 64);
    return {hi, lo};
  endfunction

  // memory and register file models
  always @(posedge clk) if (memRdEn) memRdData <= memWord(memRdAddr);
  assign regRdData = rfWord(regRdSel);

  typedef struct {
    logic [7:0]  ea;
    logic [15:0] op;
    logic        err;
    int          lat;
    int          nrd;
    logic [7:0]  rd0;
    string       tag;
  } exp_t;

  exp_t q[$];

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expectations as results appear
  int busyCnt = 0;
  int rdCnt = 0;
  logic [7:0] firstRd = '0;
  logic prevDone = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rstN === 1'b1) begin
        if (memRdEn) begin
          if (rdCnt == 0) firstRd = memRdAddr;
          rdCnt++;
        end
        if (busy) busyCnt++;
        if (done) begin
          exp_t e;
          doneSeen++;
          check("R9", "done single cycle", {31'd0, prevDone}, 32'd0);
          if (q.size() == 0) begin
            check("R10", "unexpected done", 32'd1, 32'd0);
          end else begin
            e = q.pop_front();
            check(e.tag, "operand", {16'd0, operand}, {16'd0, e.op});
            check(e.tag, "effAddr", {24'd0, effAddr}, {24'd0, e.ea});
            check(e.tag, "modeErr", {31'd0, modeErr}, {31'd0, e.err});
            check(e.tag, "latency", busyCnt, e.lat);
            check(e.tag, "read count", rdCnt, e.nrd);
            if (e.nrd > 0) check(e.tag, "first read addr", {24'd0, firstRd}, {24'd0, e.rd0});
          end
          busyCnt = 0;
          rdCnt = 0;
        end
        prevDone = done;
      end
    end
  end

  // driver: computes expectation, pushes it, drives request
  task automatic issue(input logic [2:0] m, input logic [7:0] af, input logic [2:0] rs,
                       input logic [7:0] sp, input bit noise, input string tag);
    exp_t e;
    logic [15:0] w;
    e.ea = '0; e.op = '0; e.err = 1'b0; e.lat = 1; e.nrd = 0; e.rd0 = '0; e.tag = tag;
    case (m)
      3'd0: e.op = {{8{af[7]}}, af};
      3'd1: begin e.ea = af; e.op = memWord(af); e.lat = 2; e.nrd = 1; e.rd0 = af; end
      3'd2: begin
        w = memWord(af);
        e.ea = w[7:0]; e.op = memWord(w[7:0]); e.lat = 3; e.nrd = 2; e.rd0 = af;
      end
      3'd3: e.op = rfWord(rs);
      3'd4: begin
        w = rfWord(rs);
        e.ea = w[7:0]; e.op = memWord(w[7:0]); e.lat = 2; e.nrd = 1; e.rd0 = w[7:0];
      end
      3'd5: begin
        w = rfWord(rs);
        e.ea = w[7:0] + af; e.op = memWord(e.ea); e.lat = 2; e.nrd = 1; e.rd0 = e.ea;
      end
      3'd6: begin e.ea = sp; e.op = memWord(sp); e.lat = 2; e.nrd = 1; e.rd0 = sp; end
      default: e.err = 1'b1;
    endcase
    q.push_back(e);
    issued++;
    mode = m; addrField = af; regSel = rs; stackPtr = sp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10", "busy after start", {31'd0, busy}, 32'd1);
    if (noise) begin
      mode = 3'd7; addrField = ~af; regSel = rs + 3'd1; stackPtr = ~sp; start = 1'b1;
    end
    do @(negedge clk); while (done !== 1'b1);
    start = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; mode = '0; addrField = '0; regSel = '0; stackPtr = '0;
    repeat (3) @(negedge clk);
    check("R9", "reset done", {31'd0, done}, 32'd0);
    check("R9", "reset busy", {31'd0, busy}, 32'd0);
    check("R9", "reset modeErr", {31'd0, modeErr}, 32'd0);
    check("R9", "reset operand", {16'd0, operand}, 32'd0);
    check("R9", "reset effAddr", {24'd0, effAddr}, 32'd0);
    check("R10", "reset memRdEn", {31'd0, memRdEn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    issue(3'd0, 8'h7F, 3'd0, 8'h00, 0, "R1");
    issue(3'd0, 8'h80, 3'd0, 8'h00, 0, "R1");
    issue(3'd1, 8'h20, 3'd1, 8'h00, 0, "R2");
    issue(3'd2, 8'h30, 3'd0, 8'h00, 0, "R3");
    issue(3'd3, 8'h00, 3'd3, 8'h00, 0, "R4");
    issue(3'd4, 8'h00, 3'd2, 8'h00, 0, "R5");
    issue(3'd5, 8'h40, 3'd5, 8'h00, 0, "R6");
    issue(3'd5, 8'hF0, 3'd5, 8'h00, 0, "R6");
    issue(3'd6, 8'h00, 3'd0, 8'hFE, 0, "R7");
    issue(3'd7, 8'h55, 3'd4, 8'h00, 0, "R8");
    issue(3'd3, 8'h00, 3'd7, 8'h00, 0, "R4");
    repeat (2) @(negedge clk);
    issue(3'd1, 8'hC3, 3'd0, 8'h00, 1, "R10");
    issue(3'd2, 8'h05, 3'd0, 8'h00, 1, "R10");
    issue(3'd0, 8'h01, 3'd0, 8'h00, 0, "R1");
    repeat (5) @(negedge clk);
    check("R10", "done count equals accepted requests", doneSeen, issued);
    check("R10", "no pending expectations", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL R10 watchdog actual=hung expected=complete");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule